// File: doc/BRIEF.md
# Register-Programmed SPI Master Controller

This block is a serial peripheral interface master that sits behind a simple 32-bit register bus. Software sets the clock polarity, clock phase, bit order, frame length (4 to 16 bits) and a fractional clock divider. It then turns on the master, transmit and receive paths with write-one command strobes. Each word written to the transmit register is shifted out on MOSI while MISO is shifted in, and the received word is kept in a one-entry receive buffer until it is read.

There is a one-entry transmit buffer in front of the shifter. A word that is waiting when a frame ends is loaded into the shifter on the same clock, so consecutive frames run with no idle serial clock between them. Two hardware events, transmit buffer drained and receive word stored, set flag bits. Software can also set or clear these flags through dedicated registers, and an enable mask combines them into one level interrupt. Chip selects are not part of this block. A pin-routing register is kept only as stored bits.

Top module: `spi_host_ctl`

## Requirements
- R1: After reset, the status register (0x10) reads 0x40, the flag register (0x40) reads 0, the full receive register (0x1C) reads 0, `irq` is low and `sclk` is low.
- R2: The following bits are stored and read back: control (0x00) bits 0, 8, 9 and 10; frame (0x04) bits 3:0; divider (0x14) bits 21:0; enable mask (0x4C) bits 2:1; route (0x54) bits 0, 1, 3 and 10:8. All other bits of these registers read zero.
- R3: While no frame is running, `sclk` equals control bit 8. An N-bit frame makes exactly 2N `sclk` transitions.
- R4: The frame length is N = F+3 for frame field values F from 1 to 13. F=0 gives 4 bits, and F=14 or F=15 gives 16 bits. The transmitted word comes from the low N bits of the written data.
- R5: When control bit 10 is 1, bits go out and come in MSB first. When it is 0, they go LSB first.
- R6: When control bit 9 is 0, MISO is sampled on the leading `sclk` edge (the edge away from the idle level) and MOSI changes on the trailing edge. When it is 1, MOSI changes on leading edges and MISO is sampled on trailing edges.
- R7: With divider value D, the serial half-period averages (256+D)/256 clock cycles. The k-th `sclk` edge of a frame comes ceil(k*(256+D)/256) cycles after the frame starts, so D=0 toggles `sclk` every cycle.
- R8: A write to the transmit register (0x34) is accepted only while master mode and transmit are both enabled; otherwise it has no effect. A word already waiting when a frame ends starts the next frame with no gap in `sclk`.
- R9: Command register (0x0C) strobes are: bit 0 enables receive, bit 1 disables receive, bit 2 enables transmit, bit 3 disables transmit, bit 4 enables master mode. If enable and disable are written together, disable wins. Status bit 1 shows transmit enabled.
- R10: With receive enabled, a finished frame stores its word right-aligned and zero-extended and sets status bit 7. With receive disabled, the word is dropped. Register 0x18 returns data bits 8:0 with bits 15:14 (error bits) zero. Register 0x1C returns all 16 bits. Reading either register clears status bit 7.
- R11: Status bit 6 is 1 while the transmit buffer is empty. Status bit 5 is set when a frame ends with the buffer empty and is cleared by an accepted transmit write.
- R12: Flag bit 1 is set when the transmit buffer hands a word to the shifter. Flag bit 2 is set when a received word is stored. A write to 0x44 ORs bits into the flags, and a write to 0x48 clears the written bits; a hardware event wins over a clear in the same cycle. `irq` is the OR of the flags ANDed with the enable mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq | output | 1 | Level interrupt |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The hardest state to reach from the ports is the zero-gap handover, where a second word must already be in the buffer at the clock on which the previous frame's last edge happens. The bench writes two words back to back at the fastest divider and checks that 4N edges arrive at an unbroken one-cycle spacing. A bench monitor rebuilds the MOSI word at the sampling edges for every random combination of phase, polarity, order and length. MISO is looped back through a random inverter, so the received word shows that the capture edge and the alignment are both right.

// File: rtl/spi_host_ctl.sv
module spi_host_ctl #(
  parameter int DIVW = 22,
  parameter int FRAC = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_we,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso
);
  localparam logic [DIVW:0] UNIT = {{(DIVW-FRAC){1'b0}}, 1'b1, {FRAC{1'b0}}};

  logic              sync_q, cpol_q, cpha_q, msbf_q;
  logic [3:0]        fsz_q;
  logic [DIVW-1:0]   div_q;
  logic              rx_en, tx_en, mst_en;
  logic [15:0]       txbuf, rxbuf, sh, rsh;
  logic              txfull, rxv, txc;
  logic [2:1]        flg, ien;
  logic              rt_a, rt_b, rt_c;
  logic [2:0]        rt_loc;
  logic              busy, sclk_i;
  logic [5:0]        cnt;
  logic [DIVW:0]     acc;

  logic wr, rd;
  assign wr = bus_sel & bus_we;
  assign rd = bus_sel & ~bus_we;

  logic [4:0] nb;
  assign nb = (fsz_q == 4'd0) ? 5'd4 : (fsz_q > 4'd13) ? 5'd16 : {1'b0, fsz_q} + 5'd3;

  logic [3:0] top_i;
  assign top_i = 4'(nb - 5'd1);

  logic [DIVW:0] lim, acc_nx;
  assign lim    = {1'b0, div_q} + UNIT;
  assign acc_nx = acc + UNIT;

  logic tick, last, done, start;
  assign tick  = busy && (acc_nx >= lim);
  assign last  = cnt == ({nb, 1'b0} - 6'd1);
  assign done  = tick && last;
  assign start = txfull && mst_en && tx_en && (!busy || done);

  logic samp, shf;
  assign samp = tick && (cnt[0] == cpha_q);
  assign shf  = tick && (cnt[0] != cpha_q) && (cnt != 6'd0) && !last;

  logic [15:0] rsh_nx, rx_word;
  assign rsh_nx  = !samp ? rsh : msbf_q ? {rsh[14:0], miso} : {miso, rsh[15:1]};
  assign rx_word = msbf_q ? rsh_nx : rsh_nx >> (5'd16 - nb);

  logic tx_wr_ok, pop, rx_store;
  assign tx_wr_ok = wr && bus_addr == 8'h34 && mst_en && tx_en;
  assign pop      = rd && (bus_addr == 8'h18 || bus_addr == 8'h1C);
  assign rx_store = done && rx_en;

  assign sclk = sclk_i ^ cpol_q;
  assign mosi = msbf_q ? sh[top_i] : sh[0];
  assign irq  = |(flg & ien);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 1'b0; cpol_q <= 1'b0; cpha_q <= 1'b0; msbf_q <= 1'b0;
      fsz_q  <= '0;
      div_q  <= '0;
      ien    <= '0;
      rt_a   <= 1'b0; rt_b <= 1'b0; rt_c <= 1'b0; rt_loc <= '0;
    end else if (wr) begin
      case (bus_addr)
        8'h00: begin
          sync_q <= bus_wdata[0];
          cpol_q <= bus_wdata[8];
          cpha_q <= bus_wdata[9];
          msbf_q <= bus_wdata[10];
        end
        8'h04: fsz_q <= bus_wdata[3:0];
        8'h14: div_q <= bus_wdata[DIVW-1:0];
        8'h4C: ien   <= bus_wdata[2:1];
        8'h54: begin
          rt_a   <= bus_wdata[0];
          rt_b   <= bus_wdata[1];
          rt_c   <= bus_wdata[3];
          rt_loc <= bus_wdata[10:8];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_en <= 1'b0; tx_en <= 1'b0; mst_en <= 1'b0;
    end else if (wr && bus_addr == 8'h0C) begin
      if (bus_wdata[1])      rx_en <= 1'b0;
      else if (bus_wdata[0]) rx_en <= 1'b1;
      if (bus_wdata[3])      tx_en <= 1'b0;
      else if (bus_wdata[2]) tx_en <= 1'b1;
      if (bus_wdata[4])      mst_en <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txbuf  <= '0;
      txfull <= 1'b0;
      txc    <= 1'b0;
    end else begin
      if (tx_wr_ok) begin
        txbuf  <= bus_wdata[15:0];
        txfull <= 1'b1;
      end else if (start) begin
        txfull <= 1'b0;
      end
      if (tx_wr_ok)             txc <= 1'b0;
      else if (done && !txfull) txc <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt    <= '0;
      acc    <= '0;
      sclk_i <= 1'b0;
      sh     <= '0;
      rsh    <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      cnt    <= '0;
      acc    <= '0;
      sclk_i <= 1'b0;
      sh     <= txbuf;
      rsh    <= '0;
    end else if (busy) begin
      if (tick) begin
        acc    <= acc_nx - lim;
        cnt    <= cnt + 6'd1;
        sclk_i <= ~sclk_i;
        rsh    <= rsh_nx;
        if (shf) sh <= msbf_q ? {sh[14:0], 1'b0} : {1'b0, sh[15:1]};
        if (last) busy <= 1'b0;
      end else begin
        acc <= acc_nx;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxbuf <= '0;
      rxv   <= 1'b0;
    end else if (rx_store) begin
      rxbuf <= rx_word;
      rxv   <= 1'b1;
    end else if (pop) begin
      rxv <= 1'b0;
    end
  end

  logic [2:1] fl_set, fl_clr;
  assign fl_set = (wr && bus_addr == 8'h44) ? bus_wdata[2:1] : 2'b00;
  assign fl_clr = (wr && bus_addr == 8'h48) ? bus_wdata[2:1] : 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flg <= '0;
    else        flg <= (flg & ~fl_clr) | fl_set | {rx_store, start};
  end

  always_comb begin
    case (bus_addr)
      8'h00:   bus_rdata = {21'b0, msbf_q, cpha_q, cpol_q, 7'b0, sync_q};
      8'h04:   bus_rdata = {28'b0, fsz_q};
      8'h10:   bus_rdata = {24'b0, rxv, ~txfull, txc, 3'b0, tx_en, 1'b0};
      8'h14:   bus_rdata = {{(32-DIVW){1'b0}}, div_q};
      8'h18:   bus_rdata = {16'b0, 2'b00, 5'b0, rxbuf[8:0]};
      8'h1C:   bus_rdata = {16'b0, rxbuf};
      8'h40:   bus_rdata = {29'b0, flg, 1'b0};
      8'h4C:   bus_rdata = {29'b0, ien, 1'b0};
      8'h54:   bus_rdata = {21'b0, rt_loc, 4'b0, rt_c, 1'b0, rt_b, rt_a};
      default: bus_rdata = 32'b0;
    endcase
  end
endmodule

// File: rtl/spi_host_ctl_chk.sv
module spi_host_ctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_sel,
  input logic        bus_we,
  input logic [7:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic        sclk,
  input logic        irq,
  input logic        busy,
  input logic        done,
  input logic        start,
  input logic        txfull,
  input logic        mst_en,
  input logic        tx_en,
  input logic        rx_en,
  input logic        rxv,
  input logic        cpol_q,
  input logic [2:1]  flg,
  input logic [2:1]  ien,
  input logic [5:0]  cnt,
  input logic [4:0]  nb
);
  a_r3_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sclk == cpol_q);

  a_r4_edge_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cnt < {nb, 1'b0});

  a_r8_tx_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr == 8'h34 && !(mst_en && tx_en) && !txfull) |=> !txfull);

  a_r8_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (done && txfull && mst_en && tx_en) |=> busy);

  a_r10_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && bus_addr == 8'h1C && !(done && rx_en)) |=> !rxv);

  a_r12_mask_off: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == 2'b00) |-> !irq);

  a_r12_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr == 8'h48 && bus_wdata[2:1] == 2'b11 && !start && !(done && rx_en))
      |=> flg == 2'b00);
endmodule

bind spi_host_ctl spi_host_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .sclk(sclk), .irq(irq),
  .busy(busy), .done(done), .start(start), .txfull(txfull),
  .mst_en(mst_en), .tx_en(tx_en), .rx_en(rx_en), .rxv(rxv),
  .cpol_q(cpol_q), .flg(flg), .ien(ien), .cnt(cnt), .nb(nb)
);

// File: tb/spi_host_ctl_tb.sv
module spi_host_ctl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, sclk, mosi, miso;
  logic        inv_q = 1'b0;

  assign miso = mosi ^ inv_q;

  always #4 clk = ~clk;

  spi_host_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0, edges = 0, nbit = 0, first_c = 0, last_c = 0;
  int edges0 = 0, nbit0 = 0;
  logic cfg_cpol = 1'b0, cfg_cpha = 1'b0;
  logic sclk_prev = 1'b0;
  logic cap [0:63];

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (sclk !== sclk_prev) begin
      edges = edges + 1;
      if (edges - edges0 == 1) first_c = cyc;
      last_c = cyc;
      if ((sclk_prev == cfg_cpol) ^ cfg_cpha) begin
        if (nbit - nbit0 < 64) cap[nbit - nbit0] = mosi;
        nbit = nbit + 1;
      end
    end
    sclk_prev = sclk;
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  function automatic int nbits(input int f);
    return (f == 0) ? 4 : (f > 13) ? 16 : f + 3;
  endfunction

  function automatic longint span(input int n, input longint d);
    longint l = 256 + d;
    return (2 * n * l + 255) / 256 - (l + 255) / 256;
  endfunction

  function automatic logic [15:0] mask(input int n);
    return 16'((32'h1 << n) - 1);
  endfunction

  function automatic logic [15:0] rebuild(input int n, input logic m);
    logic [15:0] w = '0;
    for (int i = 0; i < n; i++)
      if (m) w[n-1-i] = cap[i]; else w[i] = cap[i];
    return w;
  endfunction

  task automatic configure(input logic cp, input logic ph, input logic m, input int f, input int d);
    wr(8'h00, {21'b0, m, ph, cp, 8'b0});
    wr(8'h04, 32'(f));
    wr(8'h14, 32'(d));
    cfg_cpol = cp; cfg_cpha = ph;
    repeat (2) @(negedge clk);
    edges0 = edges; nbit0 = nbit;
  endtask

  task automatic wait_txc();
    logic [31:0] s;
    s = '0;
    while (!s[5]) rd(8'h10, s);
  endtask

  task automatic frame(input logic cp, input logic ph, input logic m, input int f,
                       input int d, input logic iv, input logic [15:0] w);
    logic [31:0] s, r;
    int n;
    n = nbits(f);
    configure(cp, ph, m, f, d);
    inv_q = iv;
    wr(8'h34, {16'b0, w});
    wait_txc();
    chk("R3 edge count", edges - edges0, 2 * n);
    chk("R5 R6 mosi word", rebuild(n, m), w & mask(n));
    chk("R7 edge span", last_c - first_c, span(n, d));
    rd(8'h10, s);
    chk("R11 status after frame", s, 32'hE2);
    rd(8'h1C, r);
    chk("R4 R10 rx word", r, (w ^ {16{iv}}) & mask(n));
    rd(8'h10, s);
    chk("R10 rx valid cleared", s[7], 0);
  endtask

  initial begin
    logic [31:0] v, prev;
    int dsel [0:5] = '{0, 1, 64, 128, 256, 300};
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(8'h10, v); chk("R1 status", v, 32'h40);
    rd(8'h40, v); chk("R1 flags", v, 0);
    rd(8'h1C, v); chk("R1 rx", v, 0);
    chk("R1 irq", irq, 0);
    chk("R1 sclk", sclk, 0);

    wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, v); chk("R2 control", v, 32'h701);
    wr(8'h04, 32'hFFFF_FFFF); rd(8'h04, v); chk("R2 frame", v, 32'hF);
    wr(8'h14, 32'hFFFF_FFFF); rd(8'h14, v); chk("R2 divider", v, 32'h3F_FFFF);
    wr(8'h4C, 32'hFFFF_FFFF); rd(8'h4C, v); chk("R2 enable mask", v, 32'h6);
    wr(8'h54, 32'hFFFF_FFFF); rd(8'h54, v); chk("R2 route", v, 32'h70B);
    wr(8'h4C, 0); wr(8'h00, 0); wr(8'h14, 0); wr(8'h04, 32'd5);
    edges0 = edges;

    wr(8'h34, 32'h00A5);
    repeat (40) @(negedge clk);
    rd(8'h10, v); chk("R8 write ignored status", v, 32'h40);
    chk("R8 write ignored sclk", edges - edges0, 0);

    wr(8'h0C, 32'h04); rd(8'h10, v); chk("R9 tx enable", v[1], 1);
    wr(8'h0C, 32'h0C); rd(8'h10, v); chk("R9 disable wins", v[1], 0);
    wr(8'h0C, 32'h15); rd(8'h10, v); chk("R9 all enabled", v, 32'h42);

    frame(0, 0, 1, 5, 0, 0, 16'h00A5);
    frame(1, 1, 0, 0, 0, 1, 16'h0009);
    frame(0, 1, 1, 14, 128, 0, 16'hBEEF);
    frame(1, 0, 0, 15, 256, 1, 16'h1234);

    for (int i = 0; i < 24; i++) begin
      logic [31:0] rv;
      rv = $urandom;
      frame(rv[0], rv[1], rv[2], int'(rv[7:4]), dsel[rv[10:8] % 6], rv[3], rv[31:16]);
    end

    frame(0, 0, 1, 1, 2097152, 0, 16'h000B);

    configure(0, 0, 1, 5, 0);
    inv_q = 1'b0;
    wr(8'h34, 32'h003C);
    rd(8'h10, v); chk("R11 busy clears done", v[5], 0);
    wr(8'h34, 32'h00C3);
    wait_txc();
    chk("R8 back-to-back edges", edges - edges0, 32);
    chk("R8 no gap span", last_c - first_c, 31);
    rd(8'h18, v); chk("R10 narrow rx", v, 32'h0C3);

    wr(8'h0C, 32'h02);
    frame_rx_off: begin
      configure(0, 0, 1, 5, 0);
      wr(8'h34, 32'h0055);
      wait_txc();
      rd(8'h10, v); chk("R10 rx disabled no valid", v[7], 0);
      rd(8'h1C, v); chk("R10 rx disabled keeps word", v, 32'h0C3);
    end
    wr(8'h0C, 32'h01);

    wr(8'h48, 32'h6); rd(8'h40, v); chk("R12 flags cleared", v, 0);
    wr(8'h4C, 32'h4); chk("R12 irq masked flag", irq, 0);
    wr(8'h44, 32'h4); @(negedge clk); chk("R12 set reg irq", irq, 1);
    wr(8'h48, 32'h4); @(negedge clk); chk("R12 clear reg irq", irq, 0);
    wr(8'h34, 32'h0011);
    wait_txc();
    rd(8'h40, v); chk("R12 hardware flags", v, 32'h6);
    chk("R12 irq on rx flag", irq, 1);
    wr(8'h4C, 32'h0); @(negedge clk); chk("R12 irq masked", irq, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule